// File: doc/BRIEF.md
# Buck Regulator Start-Up and Fault Sequencer

This block supervises a synchronous buck regulator. Once per switching period it receives a tick. It turns that tick count into a slowly rising reference code for the error amplifier. It also provides the code for the output-undervoltage comparator, which is always half the present reference. A single enable output gates both the high-side and the low-side gate drivers.

Three conditions stop the regulator:

- **Supply-low flag.** This has the highest priority. It stops the regulator and also clears any latched fault.
- **Shutdown request.** This is asserted when the compensation node is pulled down. It stops the regulator and restarts the ramp cleanly from zero when it is released.
- **Filtered feedback-undervoltage.** This is ignored during the first half of the ramp. Once it trips, the drivers stay off until the supply-low flag has been asserted and then released.

The analog comparators, the PWM generation and the dead-time generation lie outside this block.

Top module: `buck_start_guard`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `seq_state` is 0 (OFF), `ref_code` is 0, `uv_thr_code` is 0 and `drv_en` is 0.
- R2: `seq_state` uses a fixed encoding: 0 is OFF, 1 is ramping with the fault check blanked, 2 is ramping with the fault check armed, 3 is RUN and 4 is FAULT. `drv_en` is 1 in states 1, 2 and 3, and 0 in states 0 and 4.
- R3: From OFF with `vcc_low` and `shdn_req` both low, the next clock enters state 1 with `ref_code` equal to 0. In states 1 and 2, each clock with `cyc_tick` high raises `ref_code` by one. `uv_thr_code` always equals `ref_code` shifted right by one bit.
- R4: The tick that brings `ref_code` to 512 moves the state from 1 to 2. The 1024th tick moves the state to 3 (RUN), with `ref_code` held at 1023 from then on.
- R5: In state 1, `fb_low` has no effect, whatever its value and however long it stays high.
- R6: In states 2 and 3, eight consecutive ticks sampled with `fb_low` high move the state to 4 on the eighth tick. At that point `drv_en` goes low and `ref_code` freezes. A tick sampled with `fb_low` low restarts the count. Clocks without a tick neither advance nor restart the count.
- R7: State 4 is left neither by asserting `shdn_req` nor by releasing it. Ticks do not leave it either.
- R8: While `vcc_low` is high, the next state is 0 with `ref_code` 0. This applies in every state, including state 4. After release, the next clock starts a fresh ramp in state 1.
- R9: Outside state 4, a high `shdn_req` gives state 0 and `ref_code` 0 on the next clock, ignoring any tick. Its release starts a new ramp from 0.
- R10: Priority is `vcc_low` first, then `shdn_req`, then the undervoltage trip. A shutdown that arrives on the same tick as a trip gives state 0, not state 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | One-clock pulse per switching period |
| vcc_low | input | 1 | Supply undervoltage flag |
| shdn_req | input | 1 | Shutdown request (compensation node pulled low) |
| fb_low | input | 1 | Feedback-undervoltage comparator output |
| ref_code | output | CODE_W | Ramping reference code for the error amplifier |
| uv_thr_code | output | CODE_W | Undervoltage comparator threshold code (half of reference) |
| drv_en | output | 1 | Enable for both gate drivers |
| seq_state | output | 3 | Present sequencer state |

## Verification
The bench steps through the whole 1024-tick ramp and compares the reference, the threshold and the state at every tick. This catches an off-by-one at the blanking boundary or at the final saturation, which would show as a state change one tick early or late, or as a reference that wraps to zero.

It holds `fb_low` high across the entire blanked half and then counts the armed samples. This catches two faults: a design that arms early would trip before tick 520, and a filter that is too short or too long would trip on the wrong tick.

Two sequences separate the filter-restart rules. One breaks the run of high samples with a low sample. The other pads the run with clocks that carry no tick. A filter that ignores the low sample, or that counts the extra clocks, latches a fault the bench does not expect.

Further cases toggle shutdown while the fault is latched, apply the supply-low and shutdown flags together, and apply a shutdown on the very tick that would otherwise trip. A wrong priority order shows up as a fault that fails to clear or as a fault that survives a shutdown.

// File: rtl/bsg_pkg.sv
`timescale 1ns/1ps
package bsg_pkg;

    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_SS_BLANK = 3'd1,
        ST_SS_ARMED = 3'd2,
        ST_RUN      = 3'd3,
        ST_FAULT    = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       drv;
    } seq_regs_t;

endpackage

// File: rtl/bsg_ramp.sv
`timescale 1ns/1ps
module bsg_ramp #(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    output logic [CODE_W-1:0] count_q,
    output logic              at_top,
    output logic              at_mid_m1
);
    localparam logic [CODE_W-1:0] TOP    = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] MID_M1 = {1'b0, {(CODE_W-1){1'b1}}};
    localparam logic [CODE_W-1:0] ONE    = {{(CODE_W-1){1'b0}}, 1'b1};

    logic [CODE_W-1:0] count_d;

    assign at_top    = (count_q == TOP);
    assign at_mid_m1 = (count_q == MID_M1);

    always_comb begin
        count_d = count_q;
        if (clr) begin
            count_d = '0;
        end else if (adv && !at_top) begin
            count_d = count_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end
endmodule

// File: rtl/bsg_uv_filter.sv
`timescale 1ns/1ps
module bsg_uv_filter #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sample,
    input  logic hit,
    output logic trip
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign trip = sample && hit && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (sample) begin
            if (!hit) begin
                cnt_d = '0;
            end else if (cnt_q != LAST) begin
                cnt_d = cnt_q + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/buck_start_guard.sv
`timescale 1ns/1ps
module buck_start_guard
    import bsg_pkg::*;
#(
    parameter int CODE_W   = 10,
    parameter int FILT_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_tick,
    input  logic              vcc_low,
    input  logic              shdn_req,
    input  logic              fb_low,
    output logic [CODE_W-1:0] ref_code,
    output logic [CODE_W-1:0] uv_thr_code,
    output logic              drv_en,
    output logic [2:0]        seq_state
);
    seq_regs_t r_d, r_q;

    logic ramp_clr, ramp_adv, ramp_top, ramp_mid_m1;
    logic filt_clr, filt_sample, filt_trip;
    logic in_ramp, in_watch, stop;

    bsg_ramp #(.CODE_W(CODE_W)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ramp_clr),
        .adv       (ramp_adv),
        .count_q   (ref_code),
        .at_top    (ramp_top),
        .at_mid_m1 (ramp_mid_m1)
    );

    bsg_uv_filter #(.LEN(FILT_LEN)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (filt_clr),
        .sample (filt_sample),
        .hit    (fb_low),
        .trip   (filt_trip)
    );

    always_comb begin
        in_ramp     = (r_q.st == ST_SS_BLANK) || (r_q.st == ST_SS_ARMED);
        in_watch    = (r_q.st == ST_SS_ARMED) || (r_q.st == ST_RUN);
        stop        = vcc_low || ((r_q.st != ST_FAULT) && shdn_req);
        ramp_clr    = stop || (r_q.st == ST_OFF);
        filt_clr    = stop || !in_watch;
        filt_sample = cyc_tick && in_watch && !stop;
        ramp_adv    = cyc_tick && in_ramp && !stop && !filt_trip;

        r_d.st = r_q.st;
        if (vcc_low) begin
            r_d.st = ST_OFF;
        end else if (r_q.st == ST_FAULT) begin
            r_d.st = ST_FAULT;
        end else if (shdn_req) begin
            r_d.st = ST_OFF;
        end else if (r_q.st == ST_OFF) begin
            r_d.st = ST_SS_BLANK;
        end else if (filt_trip) begin
            r_d.st = ST_FAULT;
        end else if (ramp_adv && (r_q.st == ST_SS_BLANK) && ramp_mid_m1) begin
            r_d.st = ST_SS_ARMED;
        end else if (ramp_adv && (r_q.st == ST_SS_ARMED) && ramp_top) begin
            r_d.st = ST_RUN;
        end
        r_d.drv = (r_d.st == ST_SS_BLANK) || (r_d.st == ST_SS_ARMED) ||
                  (r_d.st == ST_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_OFF, drv: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign uv_thr_code = {1'b0, ref_code[CODE_W-1:1]};
    assign drv_en      = r_q.drv;
    assign seq_state   = r_q.st;
endmodule

// File: rtl/bsg_checker.sv
`timescale 1ns/1ps
module bsg_checker #(
    parameter int CODE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_tick,
    input logic              vcc_low,
    input logic              shdn_req,
    input logic              fb_low,
    input logic [CODE_W-1:0] ref_code,
    input logic              drv_en,
    input logic [2:0]        seq_state
);
    localparam logic [CODE_W-1:0] TOP  = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] HALF = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [CODE_W-1:0] ONE  = {{(CODE_W-1){1'b0}}, 1'b1};

    p_drv_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en == ((seq_state == 3'd1) || (seq_state == 3'd2) || (seq_state == 3'd3)));

    p_ramp_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_state == 3'd1) || (seq_state == 3'd2)) && cyc_tick && !vcc_low &&
        !shdn_req && !fb_low
        |=> (ref_code == $past(ref_code) + ONE) || ($past(ref_code) == TOP));

    p_blank_low_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 3'd1) |-> (ref_code < HALF));

    p_blank_no_trip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 3'd1) && !vcc_low |=> (seq_state != 3'd4));

    p_fault_sticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 3'd4) && !vcc_low |=> (seq_state == 3'd4));

    p_supply_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_low |=> (seq_state == 3'd0) && (ref_code == '0) && !drv_en);

    p_shdn_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_req && (seq_state != 3'd4) |=> (seq_state == 3'd0) && (ref_code == '0));
endmodule

bind buck_start_guard bsg_checker #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_tick  (cyc_tick),
    .vcc_low   (vcc_low),
    .shdn_req  (shdn_req),
    .fb_low    (fb_low),
    .ref_code  (ref_code),
    .drv_en    (drv_en),
    .seq_state (seq_state)
);

// File: tb/buck_start_guard_test.sv
`timescale 1ns/1ps
module buck_start_guard_test;
    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc_tick = 1'b0;
    logic          vcc_low = 1'b0;
    logic          shdn_req = 1'b0;
    logic          fb_low = 1'b0;
    logic [CW-1:0] ref_code, uv_thr_code;
    logic          drv_en;
    logic [2:0]    seq_state;

    int n_cmp = 0;
    int n_bad = 0;

    buck_start_guard #(.CODE_W(CW), .FILT_LEN(8)) uut (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .vcc_low(vcc_low),
        .shdn_req(shdn_req), .fb_low(fb_low), .ref_code(ref_code),
        .uv_thr_code(uv_thr_code), .drv_en(drv_en), .seq_state(seq_state)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic expect_all(input string tag, input int st, input int rf);
        chk({tag, " state"}, int'(seq_state), st);
        chk({tag, " ref"}, int'(ref_code), rf);
        chk({tag, " thr"}, int'(uv_thr_code), rf / 2);
        chk({tag, " drv (R2)"}, int'(drv_en), (st >= 1 && st <= 3) ? 1 : 0);
    endtask

    task automatic cyc(input logic t);
        cyc_tick = t;
        @(posedge clk);
        #1;
        cyc_tick = 1'b0;
    endtask

    task automatic full_ramp(input string tag);
        for (int k = 1; k <= 1024; k++) begin
            cyc(1'b1);
            expect_all((k == 512 || k == 1024) ? "R4" : tag,
                       (k < 512) ? 1 : ((k < 1024) ? 2 : 3),
                       (k > 1023) ? 1023 : k);
        end
    endtask

    initial begin
        #1;
        repeat (3) cyc(1'b0);
        expect_all("R1", 0, 0);
        rst_n = 1'b1;
        cyc(1'b0);
        expect_all("R3 start", 1, 0);

        full_ramp("R3");
        cyc(1'b1);
        expect_all("R4 saturate", 3, 1023);

        fb_low = 1'b1;
        repeat (7) cyc(1'b1);
        expect_all("R6 seven", 3, 1023);
        repeat (5) cyc(1'b0);
        expect_all("R6 no-tick clocks", 3, 1023);
        fb_low = 1'b0;
        cyc(1'b1);
        fb_low = 1'b1;
        repeat (7) cyc(1'b1);
        expect_all("R6 restart", 3, 1023);
        cyc(1'b1);
        expect_all("R6 trip", 4, 1023);

        fb_low = 1'b0;
        shdn_req = 1'b1;
        repeat (3) cyc(1'b0);
        expect_all("R7 shdn held", 4, 1023);
        shdn_req = 1'b0;
        repeat (3) cyc(1'b1);
        expect_all("R7 shdn released", 4, 1023);

        vcc_low = 1'b1;
        shdn_req = 1'b1;
        cyc(1'b1);
        expect_all("R8 R10 both", 0, 0);
        vcc_low = 1'b0;
        repeat (2) cyc(1'b1);
        expect_all("R9 still shut", 0, 0);
        shdn_req = 1'b0;
        cyc(1'b0);
        expect_all("R9 restart", 1, 0);

        fb_low = 1'b1;
        for (int k = 1; k <= 512; k++) begin
            cyc(1'b1);
            expect_all((k == 512) ? "R4" : "R5", (k < 512) ? 1 : 2, k);
        end
        repeat (7) cyc(1'b1);
        expect_all("R6 armed seven", 2, 519);
        cyc(1'b1);
        expect_all("R6 armed trip frozen", 4, 519);
        cyc(1'b1);
        expect_all("R6 frozen", 4, 519);

        vcc_low = 1'b1;
        fb_low = 1'b0;
        cyc(1'b0);
        expect_all("R8 clears fault", 0, 0);
        vcc_low = 1'b0;
        cyc(1'b0);
        expect_all("R8 release", 1, 0);

        repeat (300) cyc(1'b1);
        expect_all("R3 partial", 1, 300);
        shdn_req = 1'b1;
        cyc(1'b1);
        expect_all("R9 mid ramp", 0, 0);
        shdn_req = 1'b0;
        cyc(1'b0);
        expect_all("R9 reramp", 1, 0);
        cyc(1'b1);
        expect_all("R9 first tick", 1, 1);

        repeat (1022) cyc(1'b1);
        expect_all("R4 second ramp", 2, 1023);
        cyc(1'b1);
        expect_all("R4 second run", 3, 1023);
        fb_low = 1'b1;
        repeat (7) cyc(1'b1);
        shdn_req = 1'b1;
        cyc(1'b1);
        expect_all("R10 shdn beats trip", 0, 0);
        shdn_req = 1'b0;
        fb_low = 1'b0;
        cyc(1'b0);
        expect_all("R10 no latch", 1, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule